// File: doc/BRIEF.md
# Emulated Arbiter-Race Response Generator

This block models a delay-race physical random function entirely in ordinary synthesizable logic. A challenge word sets up a chain of switch stages, one stage for each challenge bit. Two signal paths race through the chain. At each stage the paths either run straight through or swap lanes. Two parameter tables stand in for silicon process variation. They give each stage a signed top-minus-bottom delay term for the straight setting and another for the swapped setting. At the end of the chain an arbiter decides which path would have arrived first and produces one response bit.

A sequencer builds a multi-bit response from a single chain. After a start request it evaluates the base challenge, then steps the challenge through a linear feedback shift register once per bit until all response bits are filled. The generated bits exist only while the block runs, and the chain stores no secret.

Control is plain start/busy/done. There is no data stream with back-pressure at this boundary. The caller presents a challenge with a start pulse. The result register holds its value until the caller starts another job, so a slow consumer needs no ready signal. Two instances built with different tables give different responses to the same challenge.

Top module: `puf_resp_gen`

## Requirements
- R1: While reset is asserted (rst_n low) and right after it, busy is 0, done is 0 and response is all zeros.
- R2: The chain starts with an accumulated difference of zero and processes stages in order from challenge bit 0 up to the top bit. If the stage's challenge bit is 0, the straight term for that stage (entry i of STRAIGHT_TBL, bits [i*DELAY_W +: DELAY_W], signed) is added. If the bit is 1, the accumulated difference is negated first and then the swapped term (entry i of CROSS_TBL) is added.
- R3: The response bit is 1 when the final difference is negative, meaning the top path is faster. A difference of exactly zero gives 0.
- R4: Response bit k is computed from the challenge obtained after k LFSR steps from the base challenge, and bit 0 is the least significant bit. One LFSR step shifts the challenge left by one place and puts the parity of (challenge AND LFSR_TAPS) into bit 0.
- R5: When start is sampled high while the block is idle, busy goes high on the next cycle. Done goes high for exactly one cycle, RESP_W+1 cycles after the start edge, and busy is low in that cycle.
- R6: A start request that arrives while busy is high is ignored. The running job keeps its challenge and its timing.
- R7: Response keeps its value from the done cycle until a new start is accepted, whatever happens on the challenge input.
- R8: Each instance takes its delay tables as parameters. Two instances with different tables give responses that can differ for the same challenge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request to evaluate the presented challenge; only acted on when idle |
| challenge | input | CHAL_W | Base challenge, captured when start is accepted |
| busy | output | 1 | High while response bits are being produced |
| done | output | 1 | One-cycle pulse when all response bits are valid |
| response | output | RESP_W | Assembled response, bit k from the k-th derived challenge |

## Verification
The checker assumes that start is a clean synchronous level and that the block comes out of reset before the first request. It also assumes that nothing other than start and challenge affects the outputs. The bench drives every input half a clock period away from the active edge. It leaves start high only for chosen cycles, including a deliberate overlap with a running job, so the idle-only acceptance rule is exercised under known conditions. The bench changes the challenge input between jobs to show that the held response does not follow it.

// File: rtl/puf_pkg.sv
package puf_pkg;

  // Sequencer phases.
  typedef enum logic {
    SEQ_IDLE = 1'b0,
    SEQ_RUN  = 1'b1
  } seq_state_e;

endpackage

// File: rtl/puf_delay_chain.sv
// Signed delay race through CHAL_W switch stages, accumulated combinationally.
module puf_delay_chain #(
  parameter int CHAL_W  = 16,
  parameter int DELAY_W = 8,
  parameter int ACC_W   = DELAY_W + $clog2(CHAL_W) + 1,
  parameter logic [CHAL_W*DELAY_W-1:0] STRAIGHT_TBL = '0,
  parameter logic [CHAL_W*DELAY_W-1:0] CROSS_TBL    = '0
) (
  input  logic [CHAL_W-1:0]       challenge,
  output logic signed [ACC_W-1:0] diff
);

  logic signed [ACC_W-1:0] acc [0:CHAL_W];

  assign acc[0] = '0;

  for (genvar g = 0; g < CHAL_W; g++) begin : g_stage
    localparam logic signed [DELAY_W-1:0] TERM_S = STRAIGHT_TBL[g*DELAY_W +: DELAY_W];
    localparam logic signed [DELAY_W-1:0] TERM_X = CROSS_TBL[g*DELAY_W +: DELAY_W];
    localparam logic signed [ACC_W-1:0]   EXT_S  = ACC_W'(TERM_S);
    localparam logic signed [ACC_W-1:0]   EXT_X  = ACC_W'(TERM_X);
    // Swapped lanes flip the sign of the lead carried so far.
    assign acc[g+1] = challenge[g] ? (EXT_X - acc[g]) : (acc[g] + EXT_S);
  end

  assign diff = acc[CHAL_W];

endmodule

// File: rtl/puf_arbiter.sv
// Decides the race: top path first means a negative top-minus-bottom delay.
module puf_arbiter #(
  parameter int ACC_W = 13
) (
  input  logic signed [ACC_W-1:0] diff,
  output logic                    top_wins
);

  // A tie leaves the latch in its reset state, giving 0.
  assign top_wins = diff < 0;

endmodule

// File: rtl/puf_chal_lfsr.sv
// One Fibonacci step of the challenge sequence.
module puf_chal_lfsr #(
  parameter int CHAL_W = 16,
  parameter logic [CHAL_W-1:0] TAPS = CHAL_W'(16'hB400)
) (
  input  logic [CHAL_W-1:0] cur,
  output logic [CHAL_W-1:0] nxt
);

  assign nxt = {cur[CHAL_W-2:0], ^(cur & TAPS)};

endmodule

// File: rtl/puf_resp_gen.sv
module puf_resp_gen
  import puf_pkg::*;
#(
  parameter int CHAL_W  = 16,
  parameter int RESP_W  = 8,
  parameter int DELAY_W = 8,
  parameter logic [CHAL_W-1:0] LFSR_TAPS = CHAL_W'(16'hB400),
  parameter logic [CHAL_W*DELAY_W-1:0] STRAIGHT_TBL =
    (CHAL_W*DELAY_W)'(128'hFD03F9FF06FC02FB0301FA04FE07FD05),
  parameter logic [CHAL_W*DELAY_W-1:0] CROSS_TBL =
    (CHAL_W*DELAY_W)'(128'h05FD08FA0104FE07FBFF0306F802FC09)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [CHAL_W-1:0] challenge,
  output logic              busy,
  output logic              done,
  output logic [RESP_W-1:0] response
);

  localparam int ACC_W = DELAY_W + $clog2(CHAL_W) + 1;
  localparam int IDX_W = (RESP_W > 1) ? $clog2(RESP_W) : 1;
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(RESP_W - 1);

  seq_state_e              state_q;
  logic [CHAL_W-1:0]       chal_q;
  logic [CHAL_W-1:0]       chal_nxt;
  logic [IDX_W-1:0]        idx_q;
  logic [RESP_W-1:0]       resp_q;
  logic                    done_q;
  logic signed [ACC_W-1:0] race_diff;
  logic                    race_bit;

  puf_delay_chain #(
    .CHAL_W      (CHAL_W),
    .DELAY_W     (DELAY_W),
    .ACC_W       (ACC_W),
    .STRAIGHT_TBL(STRAIGHT_TBL),
    .CROSS_TBL   (CROSS_TBL)
  ) u_chain (
    .challenge(chal_q),
    .diff     (race_diff)
  );

  puf_arbiter #(.ACC_W(ACC_W)) u_arb (
    .diff    (race_diff),
    .top_wins(race_bit)
  );

  puf_chal_lfsr #(.CHAL_W(CHAL_W), .TAPS(LFSR_TAPS)) u_step (
    .cur(chal_q),
    .nxt(chal_nxt)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= SEQ_IDLE;
      chal_q  <= '0;
      idx_q   <= '0;
      resp_q  <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (state_q)
        SEQ_IDLE: begin
          if (start) begin
            chal_q  <= challenge;
            idx_q   <= '0;
            resp_q  <= '0;
            state_q <= SEQ_RUN;
          end
        end
        SEQ_RUN: begin
          resp_q[idx_q] <= race_bit;
          chal_q        <= chal_nxt;
          if (idx_q == LAST_IDX) begin
            state_q <= SEQ_IDLE;
            done_q  <= 1'b1;
          end else begin
            idx_q <= idx_q + 1'b1;
          end
        end
        default: state_q <= SEQ_IDLE;
      endcase
    end
  end

  assign busy     = (state_q == SEQ_RUN);
  assign done     = done_q;
  assign response = resp_q;

endmodule

// File: rtl/puf_resp_gen_chk.sv
module puf_resp_gen_chk #(
  parameter int RESP_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic              busy,
  input logic              done,
  input logic [RESP_W-1:0] response
);

  localparam int CNT_W = $clog2(RESP_W + 1) + 1;

  logic [CNT_W-1:0] busy_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n || !busy) busy_cnt <= '0;
    else                 busy_cnt <= busy_cnt + 1'b1;
  end

  // R5
  busy_on_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && start) |=> busy);

  // R5
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  // R5
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R5
  run_length_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (done && busy_cnt == CNT_W'(RESP_W)));

  // R7
  resp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> $stable(response));

  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    !rst_n |=> (!busy && !done && response == '0));

endmodule

bind puf_resp_gen puf_resp_gen_chk #(.RESP_W(RESP_W)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .start   (start),
  .busy    (busy),
  .done    (done),
  .response(response)
);

// File: tb/puf_resp_gen_test.sv
`timescale 1ns/1ps
module puf_resp_gen_test;

  localparam int CW = 16;
  localparam int RW = 8;
  localparam logic [127:0] TBL_S = 128'hFD03F9FF06FC02FB0301FA04FE07FD05;
  localparam logic [127:0] TBL_X = 128'h05FD08FA0104FE07FBFF0306F802FC09;
  localparam logic [15:0]  TAPS  = 16'hB400;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic [CW-1:0] challenge = '0;
  logic          busy_a, done_a, busy_b, done_b;
  logic [RW-1:0] resp_a, resp_b;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  puf_resp_gen #(.CHAL_W(CW), .RESP_W(RW), .DELAY_W(8), .LFSR_TAPS(TAPS),
                 .STRAIGHT_TBL(TBL_S), .CROSS_TBL(TBL_X)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .challenge(challenge),
    .busy(busy_a), .done(done_a), .response(resp_a));

  // Second instance with the tables exchanged.
  puf_resp_gen #(.CHAL_W(CW), .RESP_W(RW), .DELAY_W(8), .LFSR_TAPS(TAPS),
                 .STRAIGHT_TBL(TBL_X), .CROSS_TBL(TBL_S)) uut_b (
    .clk(clk), .rst_n(rst_n), .start(start), .challenge(challenge),
    .busy(busy_b), .done(done_b), .response(resp_b));

  function automatic int race(input logic [15:0] c, input logic [127:0] st,
                              input logic [127:0] cr);
    int d = 0;
    logic signed [7:0] t;
    for (int i = 0; i < CW; i++) begin
      if (c[i]) begin t = cr[i*8 +: 8]; d = int'(t) - d; end
      else      begin t = st[i*8 +: 8]; d = d + int'(t); end
    end
    return d;
  endfunction

  function automatic logic [RW-1:0] model(input logic [15:0] base,
                                          input logic [127:0] st,
                                          input logic [127:0] cr);
    logic [15:0] c = base;
    logic [RW-1:0] r = '0;
    for (int k = 0; k < RW; k++) begin
      r[k] = race(c, st, cr) < 0;
      c = {c[14:0], ^(c & TAPS)};
    end
    return r;
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // Runs one job; optionally raises start again mid-run with another challenge.
  task automatic run_job(input logic [15:0] c, input bit intrude, output int lat);
    @(negedge clk);
    challenge = c;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    lat = 1;
    check(busy_a == 1'b1, "R5", "busy after start", 32'(busy_a), 1);
    while (!done_a && lat < 50) begin
      if (intrude && lat == 2) begin start = 1'b1; challenge = ~c; end
      if (intrude && lat == 4) start = 1'b0;
      @(negedge clk);
      lat++;
    end
    challenge = c ^ 16'h5A5A;
  endtask

  task automatic t_reset;
    check(busy_a == 0 && done_a == 0, "R1", "busy/done in reset", {busy_a, done_a}, 0);
    check(resp_a == '0, "R1", "response in reset", 32'(resp_a), 0);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    check(busy_a == 0 && done_a == 0 && resp_a == '0, "R1", "state after reset",
          32'(resp_a), 0);
  endtask

  task automatic t_pattern(input logic [15:0] c);
    int lat;
    logic [RW-1:0] ea, eb;
    ea = model(c, TBL_S, TBL_X);
    eb = model(c, TBL_X, TBL_S);
    run_job(c, 1'b0, lat);
    check(lat == RW + 1, "R5", "done latency", 32'(lat), RW + 1);
    check(!busy_a, "R5", "busy low with done", 32'(busy_a), 0);
    check(resp_a == ea, "R2", $sformatf("R4 response ch=%h", c), 32'(resp_a), 32'(ea));
    check(resp_b == eb, "R8", $sformatf("second table ch=%h", c), 32'(resp_b), 32'(eb));
    @(negedge clk);
    check(!done_a, "R5", "done one cycle", 32'(done_a), 0);
  endtask

  task automatic t_tie;
    int lat;
    check(race(16'h0000, TBL_S, TBL_X) == 0, "R3", "bench tie setup",
          32'(race(16'h0000, TBL_S, TBL_X)), 0);
    run_job(16'h0000, 1'b0, lat);
    check(resp_a[0] == 1'b0, "R3", "zero difference resolves to 0", 32'(resp_a), 0);
  endtask

  task automatic t_negative;
    int lat;
    logic [RW-1:0] ea;
    ea = model(16'h0001, TBL_S, TBL_X);
    check(ea != '0, "R3", "bench expects a top-first bit", 32'(ea), 1);
    run_job(16'h0001, 1'b0, lat);
    check(resp_a == ea, "R3", "negative difference gives 1", 32'(resp_a), 32'(ea));
  endtask

  task automatic t_ignore_busy;
    int lat;
    logic [RW-1:0] ea;
    ea = model(16'hC0DE, TBL_S, TBL_X);
    run_job(16'hC0DE, 1'b1, lat);
    check(lat == RW + 1, "R6", "timing with intruding start", 32'(lat), RW + 1);
    check(resp_a == ea, "R6", "response kept original challenge", 32'(resp_a), 32'(ea));
    @(negedge clk);
    check(!busy_a, "R6", "no second job launched", 32'(busy_a), 0);
  endtask

  task automatic t_hold;
    int lat;
    logic [RW-1:0] ea;
    ea = model(16'h3C69, TBL_S, TBL_X);
    run_job(16'h3C69, 1'b0, lat);
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      challenge = 16'(i * 16'h1357);
    end
    check(resp_a == ea, "R7", "response held while idle", 32'(resp_a), 32'(ea));
  endtask

  task automatic t_instances;
    int lat;
    int differ = 0;
    logic [15:0] set [4] = '{16'hA5C3, 16'h1234, 16'hFFFF, 16'h8000};
    for (int i = 0; i < 4; i++) begin
      run_job(set[i], 1'b0, lat);
      if (resp_a != resp_b) differ++;
    end
    check(differ > 0, "R8", "instances differ on some challenge", 32'(differ), 1);
  endtask

  initial begin
    #(4 * 100000);
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (2) @(negedge clk);
    t_reset();
    t_pattern(16'hA5C3);
    t_pattern(16'hFFFF);
    t_pattern(16'h1234);
    t_pattern(16'h8000);
    t_tie();
    t_negative();
    t_ignore_busy();
    t_hold();
    t_instances();
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule